// File: doc/BRIEF.md
# Coherent Single-Line Snooping Cache Cluster

This block is a cluster of small write-back caches, one per rasterization unit, sharing a single 256-bit memory bus. Each cache holds exactly one 256-bit line with a valid bit and a dirty bit. Its rasterizer makes 32-bit word accesses, which the cache merges into or extracts from the line. Whole lines move to and from memory in single 256-bit bus transactions.

Coherency works through ownership. Each cache broadcasts the line it holds and, while it waits for a miss to be filled, the line it wants. A cache that sees a peer wanting its line flushes it (writing it back if dirty) and invalidates it. A cache fills a line only when no peer holds it, so each line has at most one owner. A round-robin arbiter grants the bus to one cache per transaction and keeps that grant until the transaction ends.

On a miss, a cache first writes back its old line if it is dirty, then releases it, and only then waits for the new line. It never holds one line while waiting for another, so two caches cannot deadlock on each other. A freshly filled line serves at least one access of its own rasterizer before it can be taken away, so two caches competing for one line cannot livelock.

Top module: `lsc_cluster`

## Requirements
- R1: A read that hits returns the 32-bit word selected by the low three word-address bits (word k at line bits 32k+31..32k). `rq_ack` pulses high for exactly one cycle, in the cycle after the request is accepted, with the data on `rq_rdata`.
- R2: A write updates only the selected 32-bit word of the line and marks the line dirty. Any later read of that address, from any cache, returns the written value.
- R3: On a miss while the held line is dirty, the cache performs one 256-bit write transaction (`mem_we`=1) of the old line before the read transaction that fills the new line.
- R4: On a miss while the held line is clean or invalid, the cache performs only the fill read and no write transaction.
- R5: At no time do two caches hold the same line address valid.
- R6: A request for a line held by a peer keeps its rasterizer waiting until the peer has written the line back (if dirty) and released it. The data returned is the peer's latest data.
- R7: Bus grants are one-hot, stay fixed until the transaction completes (`mem_valid` and `mem_ready` both high), and go round-robin: after cache g is served, the next grant goes to the first requester in order g+1, g+2, ... wrapping from NCACHE-1 to 0. After reset the search starts at cache 0.
- R8: A freshly filled line serves its own pending access before it can be released to a peer. Two caches writing different words of one line at the same time both complete, and both words persist.
- R9: After reset, `rq_ack`, `rq_stall` and `mem_valid` are low and every line is invalid, so the first access of any cache causes a fill read.
- R10: `rq_stall` is high for a cache while its request is high and not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_req | input | NCACHE | Access request per rasterizer, held until acknowledged |
| rq_we | input | NCACHE | 1 = write, 0 = read, per rasterizer |
| rq_addr | input | NCACHE*AW | Word address per rasterizer |
| rq_wdata | input | NCACHE*WW | Write word per rasterizer |
| rq_ack | output | NCACHE | One-cycle completion pulse per rasterizer |
| rq_rdata | output | NCACHE*WW | Returned word, valid with `rq_ack` |
| rq_stall | output | NCACHE | Rasterizer must wait |
| mem_valid | output | 1 | Bus transaction active |
| mem_we | output | 1 | 1 = line write-back, 0 = line fill |
| mem_line_addr | output | AW-3 | Line address of the transaction |
| mem_wdata | output | LW | Line written back |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | LW | Line returned for a fill |

## Verification
The hardest situations to reach are those where ownership moves while caches compete. One case is a dirty line held by one cache while another misses on it. Another is several caches missing in the same cycle, so that the grant order becomes visible, including the wrap from the top index back to cache 0. The bench sets the first case up by writing a line from one cache and then reading it from another. For the second, it launches concurrent accesses from several caches whose previous grant history it controls, and logs the order of the bus transactions. Two caches writing one line in the same cycle drive the fresh-fill rule, and the bench checks afterwards that both words survived.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_WAIT} cache_st_t;
endpackage

// File: rtl/lsc_rr_arbiter.sv
module lsc_rr_arbiter #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         xfer_done,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] pick;
  logic          any_req;
  logic          holder_req;

  function automatic logic [IW-1:0] rr_pick(logic [N-1:0] r, logic [IW-1:0] last);
    logic [IW-1:0] p;
    logic          found;
    p = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!found && r[idx]) begin
        found = 1'b1;
        p = IW'(idx);
      end
    end
    return p;
  endfunction

  assign pick       = rr_pick(req, last_q);
  assign any_req    = |req;
  assign holder_req = |(req & gnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt    <= '0;
      last_q <= IW'(N - 1);
    end else if (gnt == '0) begin
      if (any_req) begin
        gnt    <= N'(1) << pick;
        last_q <= pick;
      end
    end else if (xfer_done || !holder_req) begin
      gnt <= '0;
    end
  end

  assert_onehot_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && holder_req && !xfer_done) |=> (gnt == $past(gnt)));
endmodule

// File: rtl/lsc_line_cache.sv
module lsc_line_cache
  import lsc_pkg::*;
#(
  parameter int AW = 16,
  parameter int WW = 32,
  parameter int LW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [WW-1:0] wdata,
  output logic          ack,
  output logic [WW-1:0] rdata,
  output logic          stall,
  output logic          hold_valid,
  output logic [AW-$clog2(LW/WW)-1:0] hold_tag,
  output logic          want_valid,
  output logic [AW-$clog2(LW/WW)-1:0] want_tag,
  input  logic          peer_hold_hit,
  input  logic          peer_want_hit,
  output logic          bus_req,
  input  logic          grant,
  output logic          bus_we,
  output logic [AW-$clog2(LW/WW)-1:0] bus_addr,
  output logic [LW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [LW-1:0] bus_rdata
);
  localparam int WPL = LW / WW;
  localparam int OW  = $clog2(WPL);
  localparam int TW  = AW - OW;

  function automatic logic [WW-1:0] get_word(logic [LW-1:0] ln, logic [OW-1:0] o);
    return ln[o*WW +: WW];
  endfunction

  function automatic logic [LW-1:0] put_word(logic [LW-1:0] ln, logic [OW-1:0] o,
                                             logic [WW-1:0] w);
    logic [LW-1:0] r;
    r = ln;
    r[o*WW +: WW] = w;
    return r;
  endfunction

  cache_st_t     state;
  logic [LW-1:0] line_q;
  logic [TW-1:0] tag_q;
  logic [TW-1:0] pend_q;
  logic          valid_q, dirty_q, fresh_q, ack_q, wb_to_wait_q;
  logic [WW-1:0] rdata_q;

  logic [TW-1:0] req_tag;
  logic [OW-1:0] req_off;
  logic          hit, take;
  logic          serve_ev, release_ev, miss_ev, bus_go, done_ev;

  assign req_tag    = addr[AW-1:OW];
  assign req_off    = addr[OW-1:0];
  assign hit        = valid_q && (tag_q == req_tag);
  assign take       = req && !ack_q;
  assign release_ev = (state == ST_IDLE) && valid_q && peer_want_hit && !fresh_q;
  assign serve_ev   = (state == ST_IDLE) && take && hit && !release_ev;
  assign miss_ev    = (state == ST_IDLE) && take && !hit && !release_ev;
  assign bus_req    = (state == ST_WB) || ((state == ST_WAIT) && !peer_hold_hit);
  assign bus_go     = grant && bus_req;
  assign done_ev    = bus_go && bus_ready;

  assign ack        = ack_q;
  assign rdata      = rdata_q;
  assign stall      = req && !ack_q;
  assign hold_valid = valid_q;
  assign hold_tag   = tag_q;
  assign want_valid = (state == ST_WAIT);
  assign want_tag   = pend_q;
  assign bus_we     = (state == ST_WB);
  assign bus_addr   = (state == ST_WB) ? tag_q : pend_q;
  assign bus_wdata  = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      line_q       <= '0;
      tag_q        <= '0;
      pend_q       <= '0;
      valid_q      <= 1'b0;
      dirty_q      <= 1'b0;
      fresh_q      <= 1'b0;
      ack_q        <= 1'b0;
      wb_to_wait_q <= 1'b0;
      rdata_q      <= '0;
    end else begin
      ack_q <= serve_ev;
      case (state)
        ST_IDLE: begin
          if (!req) fresh_q <= 1'b0;
          if (release_ev) begin
            if (dirty_q) begin
              state        <= ST_WB;
              wb_to_wait_q <= 1'b0;
            end else begin
              valid_q <= 1'b0;
            end
          end else if (serve_ev) begin
            fresh_q <= 1'b0;
            if (we) begin
              line_q  <= put_word(line_q, req_off, wdata);
              dirty_q <= 1'b1;
              rdata_q <= wdata;
            end else begin
              rdata_q <= get_word(line_q, req_off);
            end
          end else if (miss_ev) begin
            pend_q <= req_tag;
            if (valid_q && dirty_q) begin
              state        <= ST_WB;
              wb_to_wait_q <= 1'b1;
            end else begin
              valid_q <= 1'b0;
              state   <= ST_WAIT;
            end
          end
        end
        ST_WB: begin
          if (done_ev) begin
            valid_q <= 1'b0;
            dirty_q <= 1'b0;
            state   <= wb_to_wait_q ? ST_WAIT : ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (done_ev) begin
            line_q  <= bus_rdata;
            tag_q   <= pend_q;
            valid_q <= 1'b1;
            dirty_q <= 1'b0;
            fresh_q <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ack_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_serve_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(valid_q));
  assert_wb_before_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !valid_q);
  assert_fill_only_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_go && !bus_we) |-> !peer_hold_hit);
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |-> stall);
endmodule

// File: rtl/lsc_cluster.sv
module lsc_cluster #(
  parameter int NCACHE = 11,
  parameter int AW     = 16,
  parameter int WW     = 32,
  parameter int LW     = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCACHE-1:0]    rq_req,
  input  logic [NCACHE-1:0]    rq_we,
  input  logic [NCACHE*AW-1:0] rq_addr,
  input  logic [NCACHE*WW-1:0] rq_wdata,
  output logic [NCACHE-1:0]    rq_ack,
  output logic [NCACHE*WW-1:0] rq_rdata,
  output logic [NCACHE-1:0]    rq_stall,
  output logic                 mem_valid,
  output logic                 mem_we,
  output logic [AW-$clog2(LW/WW)-1:0] mem_line_addr,
  output logic [LW-1:0]        mem_wdata,
  input  logic                 mem_ready,
  input  logic [LW-1:0]        mem_rdata
);
  localparam int OW = $clog2(LW / WW);
  localparam int TW = AW - OW;

  logic [NCACHE-1:0] hv, wv, phit, pwant, breq, bwe, gnt;
  logic [TW-1:0]     ht [NCACHE];
  logic [TW-1:0]     wt [NCACHE];
  logic [TW-1:0]     ba [NCACHE];
  logic [LW-1:0]     bw [NCACHE];
  logic              xfer_done;
  int                dup_cnt;

  for (genvar i = 0; i < NCACHE; i++) begin : g_cache
    lsc_line_cache #(.AW(AW), .WW(WW), .LW(LW)) u_cache (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (rq_req[i]),
      .we           (rq_we[i]),
      .addr         (rq_addr[i*AW +: AW]),
      .wdata        (rq_wdata[i*WW +: WW]),
      .ack          (rq_ack[i]),
      .rdata        (rq_rdata[i*WW +: WW]),
      .stall        (rq_stall[i]),
      .hold_valid   (hv[i]),
      .hold_tag     (ht[i]),
      .want_valid   (wv[i]),
      .want_tag     (wt[i]),
      .peer_hold_hit(phit[i]),
      .peer_want_hit(pwant[i]),
      .bus_req      (breq[i]),
      .grant        (gnt[i]),
      .bus_we       (bwe[i]),
      .bus_addr     (ba[i]),
      .bus_wdata    (bw[i]),
      .bus_ready    (mem_ready),
      .bus_rdata    (mem_rdata)
    );
  end

  // Snoop channel: each cache compares its wanted/held tag with every peer.
  always_comb begin
    phit = '0;
    pwant = '0;
    for (int i = 0; i < NCACHE; i++) begin
      for (int j = 0; j < NCACHE; j++) begin
        if (j != i) begin
          if (wv[i] && hv[j] && (ht[j] == wt[i])) phit[i] = 1'b1;
          if (hv[i] && wv[j] && (wt[j] == ht[i])) pwant[i] = 1'b1;
        end
      end
    end
  end

  // Bus mux driven by the granted cache.
  always_comb begin
    mem_valid     = 1'b0;
    mem_we        = 1'b0;
    mem_line_addr = '0;
    mem_wdata     = '0;
    for (int i = 0; i < NCACHE; i++) begin
      if (gnt[i]) begin
        mem_valid     = breq[i];
        mem_we        = bwe[i];
        mem_line_addr = ba[i];
        mem_wdata     = bw[i];
      end
    end
  end

  assign xfer_done = mem_valid && mem_ready;

  lsc_rr_arbiter #(.N(NCACHE)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (breq),
    .xfer_done(xfer_done),
    .gnt      (gnt)
  );

  always_comb begin
    dup_cnt = 0;
    for (int i = 0; i < NCACHE; i++)
      for (int j = i + 1; j < NCACHE; j++)
        if (hv[i] && hv[j] && (ht[i] == ht[j])) dup_cnt++;
  end

  assert_exclusive_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dup_cnt == 0);
  assert_bus_only_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (gnt != '0));
endmodule

// File: tb/lsc_cluster_bench.sv
module lsc_cluster_bench;
  localparam int NC = 11;
  localparam int AW = 16;
  localparam int WW = 32;
  localparam int LW = 256;
  localparam int TW = AW - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NC-1:0]    b_req = '0, b_we = '0;
  logic [NC*AW-1:0] b_addr = '0;
  logic [NC*WW-1:0] b_wd = '0;
  logic [NC-1:0]    rq_ack, rq_stall;
  logic [NC*WW-1:0] rq_rdata;
  logic             mem_valid, mem_we, mem_ready;
  logic [TW-1:0]    mem_line_addr;
  logic [LW-1:0]    mem_wdata, mem_rdata;

  lsc_cluster #(.NCACHE(NC), .AW(AW), .WW(WW), .LW(LW)) u_lsc_cluster (
    .clk(clk), .rst_n(rst_n),
    .rq_req(b_req), .rq_we(b_we), .rq_addr(b_addr), .rq_wdata(b_wd),
    .rq_ack(rq_ack), .rq_rdata(rq_rdata), .rq_stall(rq_stall),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_line_addr(mem_line_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] init_word(int ln, int w);
    return 32'hA000_0000 | (ln << 8) | w;
  endfunction

  // Memory model: 16 lines, completes a transaction in its second cycle.
  logic [LW-1:0] mem [16];
  int mcnt = 0;
  assign mem_ready = mem_valid && (mcnt == 1);
  assign mem_rdata = mem[mem_line_addr[3:0]];

  int nrd = 0, nwr = 0, nlog = 0;
  int log_line [64];
  bit log_we [64];

  always @(posedge clk) begin
    if (mem_valid && !mem_ready) mcnt <= mcnt + 1;
    else mcnt <= 0;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) begin
        nwr <= nwr + 1;
        mem[mem_line_addr[3:0]] <= mem_wdata;
      end else nrd <= nrd + 1;
      if (nlog < 64) begin
        log_line[nlog] <= int'(mem_line_addr);
        log_we[nlog]   <= mem_we;
        nlog <= nlog + 1;
      end
    end
  end

  logic [31:0] sh [128];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(int c, bit we, int ln, int off, logic [31:0] wd, string req);
    logic [31:0] got;
    int n;
    @(negedge clk);
    b_req[c] = 1'b1;
    b_we[c] = we;
    b_addr[c*AW +: AW] = AW'(ln * 8 + off);
    b_wd[c*WW +: WW] = wd;
    n = 0;
    while (n < 400) begin
      @(negedge clk);
      if (rq_ack[c]) break;
      n++;
    end
    got = rq_rdata[c*WW +: WW];
    b_req[c] = 1'b0;
    if (n >= 400) chk(0, req, 32'h0, 32'h1);
    else if (we) sh[ln*8 + off] = wd;
    else chk(got == sh[ln*8 + off], req, got, sh[ln*8 + off]);
  endtask

  // Table: {cache[4], we[1], line[4], offset[3], data[32]}
  localparam logic [43:0] TBL [12] = '{
    {4'd0, 1'b1, 4'd0, 3'd0, 32'h1111_1111},
    {4'd0, 1'b0, 4'd0, 3'd0, 32'h0},
    {4'd0, 1'b1, 4'd0, 3'd7, 32'h7777_7777},
    {4'd0, 1'b0, 4'd0, 3'd7, 32'h0},
    {4'd0, 1'b0, 4'd0, 3'd3, 32'h0},
    {4'd1, 1'b0, 4'd0, 3'd7, 32'h0},
    {4'd1, 1'b1, 4'd1, 3'd2, 32'h2222_2222},
    {4'd2, 1'b0, 4'd1, 3'd2, 32'h0},
    {4'd0, 1'b0, 4'd0, 3'd0, 32'h0},
    {4'd2, 1'b1, 4'd2, 3'd5, 32'h5555_5555},
    {4'd2, 1'b0, 4'd1, 3'd2, 32'h0},
    {4'd1, 1'b0, 4'd2, 3'd5, 32'h0}
  };

  initial begin
    for (int l = 0; l < 16; l++)
      for (int w = 0; w < 8; w++) begin
        mem[l][w*32 +: 32] = init_word(l, w);
        sh[l*8 + w] = init_word(l, w);
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rq_ack == '0, "R9 ack after reset", 32'(rq_ack), 32'h0);
    chk(rq_stall == '0, "R9 stall after reset", 32'(rq_stall), 32'h0);
    chk(mem_valid == 1'b0, "R9 bus idle after reset", 32'(mem_valid), 32'h0);

    // Table walk: R1 word select, R2 write merge, R6 ownership moves
    for (int i = 0; i < 12; i++) begin
      access(int'(TBL[i][43:40]), TBL[i][39], int'(TBL[i][38:35]),
             int'(TBL[i][34:32]), TBL[i][31:0], "R1/R2/R6 table");
      if (i == 0) begin
        chk(nrd == 1, "R9 first access fills", 32'(nrd), 32'd1);
        chk(nwr == 0, "R9 first access no write", 32'(nwr), 32'd0);
      end
    end

    // R4: clean misses only read
    begin
      int r0, w0;
      access(2, 0, 4, 1, 0, "R4 read line4");
      r0 = nrd; w0 = nwr;
      access(2, 0, 5, 6, 0, "R4 read line5");
      chk(nrd - r0 == 1, "R4 fill count", 32'(nrd - r0), 32'd1);
      chk(nwr == w0, "R4 no write-back", 32'(nwr - w0), 32'd0);
    end

    // R3: dirty miss writes back before the fill
    begin
      int k0;
      access(2, 1, 5, 3, 32'hDEAD_0003, "R2 write line5");
      k0 = nlog;
      access(2, 0, 6, 0, 0, "R3 read line6");
      chk(nlog - k0 == 2, "R3 two transactions", 32'(nlog - k0), 32'd2);
      chk(log_we[k0] == 1 && log_line[k0] == 5, "R3 write-back first line5",
          32'(log_line[k0]), 32'd5);
      chk(log_we[k0+1] == 0 && log_line[k0+1] == 6, "R3 fill second line6",
          32'(log_line[k0+1]), 32'd6);
      access(3, 0, 5, 3, 0, "R2 written word from memory");
    end

    // R6/R10: peer owns dirty line, requester stalls until flush
    begin
      int w0;
      access(3, 1, 9, 2, 32'hCAFE_0902, "R2 write line9");
      w0 = nwr;
      fork
        access(4, 0, 9, 2, 0, "R6 read peer-owned line9");
        begin
          repeat (2) @(negedge clk);
          chk(rq_stall[4] == 1'b1, "R10 stall while waiting", 32'(rq_stall[4]), 32'd1);
        end
      join
      chk(nwr - w0 == 1, "R6 peer flushed once", 32'(nwr - w0), 32'd1);
    end

    // R7: round-robin order after cache 4 was last served
    begin
      int k0;
      k0 = nlog;
      fork
        access(7, 0, 13, 0, 0, "R7 c7 read");
        access(5, 0, 10, 0, 0, "R7 c5 read");
        access(6, 0, 11, 0, 0, "R7 c6 read");
      join
      chk(log_line[k0] == 10, "R7 first grant c5", 32'(log_line[k0]), 32'd10);
      chk(log_line[k0+1] == 11, "R7 second grant c6", 32'(log_line[k0+1]), 32'd11);
      chk(log_line[k0+2] == 13, "R7 third grant c7", 32'(log_line[k0+2]), 32'd13);
      k0 = nlog;
      fork
        access(6, 0, 12, 0, 0, "R7 c6 read");
        access(5, 0, 15, 0, 0, "R7 c5 read");
        access(8, 0, 14, 0, 0, "R7 c8 read");
        access(1, 0, 7, 0, 0, "R7 c1 read");
      join
      chk(log_line[k0] == 14, "R7 after c7 goes c8", 32'(log_line[k0]), 32'd14);
      chk(log_line[k0+1] == 7, "R7 wrap to c1", 32'(log_line[k0+1]), 32'd7);
      chk(log_line[k0+2] == 15, "R7 then c5", 32'(log_line[k0+2]), 32'd15);
      chk(log_line[k0+3] == 12, "R7 then c6", 32'(log_line[k0+3]), 32'd12);
    end

    // R8: two caches write one line at once; both complete, both persist
    fork
      access(9, 1, 3, 1, 32'h9999_0301, "R8 c9 write");
      access(10, 1, 3, 6, 32'hAAAA_0306, "R8 c10 write");
    join
    access(0, 0, 3, 1, 0, "R8 word1 persists");
    access(0, 0, 3, 6, 0, "R8 word6 persists");
    access(0, 0, 3, 0, 0, "R2 untouched word");

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule